// File: doc/BRIEF.md
# Clock-Chip Square-Wave Output Controller

This block holds the eight-bit output-control byte of a real-time clock and drives the chip's single square-wave/output pin from it. Software writes the byte through a one-cycle write strobe. The block watches a level that follows the 32.768 kHz timekeeping oscillator and has already been brought into the system clock domain. It counts both edges of that level, so it gets 65,536 timing events per second. Every output rate is a whole number of these half-oscillator events, which also makes the top rate of 32.768 kHz reachable with a 50 % duty cycle.

When the enable bit of the byte is clear, the pin drives the static level bit. When the enable bit is set, the pin carries a square wave whose frequency is set by the two-bit rate field. The four reserved bits are stored and read back but do not affect the pin. A write that changes the enable or the rate restarts the divider, so the new waveform begins with a full low half-period. A write that leaves both unchanged does not disturb a waveform that is already running.

Top module: `sqw_out_ctrl`

## Requirements
- R1: After reset the stored control byte reads 0x03 (rate field 11, enable clear, level bit clear) and the pin is low.
- R2: A write strobe stores all eight data bits, and they appear on `ctrl_byte` in the cycle after the strobe.
- R3: With enable (bit 4) clear, the pin equals bit 7 and stays there whatever the oscillator does.
- R4: With enable set, the pin toggles once every H counted oscillator edges, giving a 50 % duty cycle. H depends on bits 1:0: 00 gives SLOW_HALF (32768 by default, 1 Hz), 01 gives 8 (4.096 kHz), 10 gives 4 (8.192 kHz) and 11 gives 1 (32.768 kHz).
- R5: Rising and falling edges of `osc_lvl` both count. The pin changes only in the cycle after a counted edge, a restart, or a disable.
- R6: A write that changes bit 4 or bits 1:0 resets the divider, so the pin is low and the next toggle comes only after H further edges.
- R7: A write that leaves bit 4 and bits 1:0 unchanged keeps the running count and phase.
- R8: Reserved bits 6, 5, 3 and 2 have no effect on the pin.
- R9: With enable set, bit 7 has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | One-cycle write strobe for the control byte |
| ctrl_wr_data | input | 8 | Control byte value to store |
| osc_lvl | input | 1 | 32.768 kHz oscillator level, synchronous to clk |
| ctrl_byte | output | 8 | Stored control byte |
| sqw_pin | output | 1 | Square-wave / static output pin level |

## Verification
The bench sweeps every rate code with both values of the level bit, with the reserved bits both clear and set. It checks the pin after each oscillator edge against the phase computed from the edge count, so an error in a divisor, in duty, or in edge counting shows up, and so does leakage from the level or reserved bits. With enable clear, it drives oscillator edges under every rate and expects no change on the pin. A mid-waveform write that changes the rate, and another that touches only reserved bits, tell a proper restart apart from an unwanted disturbance of the running phase.

// File: rtl/sqw_pkg.sv
// Shared types for the square-wave output controller.
// Assumes the control byte packs the level, enable and rate fields at fixed positions.
package sqw_pkg;
    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic       lvl;     // bit 7: static pin level
        logic [1:0] rsv_hi;  // bits 6:5 reserved
        logic       en;      // bit 4: square-wave enable
        logic [1:0] rsv_lo;  // bits 3:2 reserved
        rate_e      rate;    // bits 1:0: rate select
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h03;

    // Half-period length in counted oscillator edges for a rate code.
    function automatic int unsigned half_len(input rate_e r, input int unsigned slow);
        case (r)
            RATE_SLOW: half_len = slow;
            RATE_4K:   half_len = 8;
            RATE_8K:   half_len = 4;
            default:   half_len = 1;
        endcase
    endfunction
endpackage

// File: rtl/sqw_ctrl_reg.sv
// Control byte register. It stores every written bit and flags a restart when
// a write changes the enable bit or the rate field.
// Assumes the write strobe lasts one cycle per write.
module sqw_ctrl_reg
    import sqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl_q,
    output logic       restart
);
    ctrl_t wr_view;

    // Split the incoming byte into its fields.
    always_comb wr_view = ctrl_t'(wr_data);

    // Request a restart only when the enable or rate actually changes.
    always_comb restart = wr_en && ((wr_view.en != ctrl_q.en) || (wr_view.rate != ctrl_q.rate));

    // Hold the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (wr_en) ctrl_q <= wr_view;
    end

    // R2: a written byte is stored whole.
    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == ctrl_t'($past(wr_data))));
endmodule

// File: rtl/sqw_osc_edge.sv
// Detects both edges of the synchronized oscillator level.
// Assumes osc_lvl is already synchronous to clk and changes at most once per cycle.
module sqw_osc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_lvl,
    output logic edge_o
);
    logic osc_d;

    // Remember the previous oscillator level.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_d <= 1'b0;
        else        osc_d <= osc_lvl;
    end

    // An edge is any difference from the previous level.
    always_comb edge_o = osc_lvl ^ osc_d;
endmodule

// File: rtl/sqw_divider.sv
// Divides the counted oscillator edges down to the selected half-period and
// toggles a phase bit. It is held cleared while disabled or on restart.
// Assumes SLOW_HALF >= 8 so every rate fits the counter.
module sqw_divider
    import sqw_pkg::*;
#(
    parameter int unsigned SLOW_HALF = 32768
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  run,
    input  logic  edge_i,
    input  rate_e rate,
    output logic  phase
);
    localparam int unsigned CW = $clog2(SLOW_HALF);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    // Last count value of the current half-period.
    always_comb half_m1 = CW'(half_len(rate, SLOW_HALF) - 1);

    // Count edges and flip the phase at the end of each half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (edge_i) begin
            if (cnt >= half_m1) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: the count never passes the half-period of the active rate.
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= half_m1);
    // R5: the phase moves only after an edge, a restart or a disable.
    p_phase_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> $past(edge_i || restart || !run));
    // R6: a restart leaves a clean, low, zero-count divider.
    p_restart_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && phase == 1'b0));
endmodule

// File: rtl/sqw_out_ctrl.sv
// Top of the square-wave output controller. It ties together the control
// register, the oscillator edge detector and the divider, and selects the pin
// level. Assumes osc_lvl is already in the clk domain.
module sqw_out_ctrl
    import sqw_pkg::*;
#(
    parameter int unsigned SLOW_HALF = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_en,
    input  logic [7:0] ctrl_wr_data,
    input  logic       osc_lvl,
    output logic [7:0] ctrl_byte,
    output logic       sqw_pin
);
    ctrl_t ctrl;
    logic  restart;
    logic  osc_edge;
    logic  phase;

    sqw_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr_en),
        .wr_data (ctrl_wr_data),
        .ctrl_q  (ctrl),
        .restart (restart)
    );

    sqw_osc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_lvl (osc_lvl),
        .edge_o  (osc_edge)
    );

    sqw_divider #(.SLOW_HALF(SLOW_HALF)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (ctrl.en),
        .edge_i  (osc_edge),
        .rate    (ctrl.rate),
        .phase   (phase)
    );

    // Expose the stored byte.
    always_comb ctrl_byte = 8'(ctrl);

    // Pin carries the waveform when enabled, otherwise the static level.
    always_comb sqw_pin = ctrl.en ? phase : ctrl.lvl;

    // R3: with the waveform off and the byte unchanged, the pin holds still.
    p_static_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && $stable(ctrl)) |-> $stable(sqw_pin));
    // R1: leaving reset gives the documented default byte.
    p_reset_byte_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_byte == CTRL_RESET));
endmodule

// File: tb/sqw_out_ctrl_tb.sv
// Sweeping bench: every rate, level and reserved pattern, phase computed from edge count.
module sqw_out_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       osc = 1'b0;
    logic [7:0] ctrl_byte;
    logic       pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sqw_out_ctrl #(.SLOW_HALF(SLOW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_en   (wr_en),
        .ctrl_wr_data (wr_data),
        .osc_lvl      (osc),
        .ctrl_byte    (ctrl_byte),
        .sqw_pin      (pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'b00: half_of = SLOW;
            2'b01: half_of = 8;
            2'b10: half_of = 4;
            default: half_of = 1;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        osc = ~osc;
        @(negedge clk);
    endtask

    // Run n edges, expecting the waveform phase to start from edge index k0.
    task automatic run_wave(input string tag, input logic [1:0] r, input int k0, input int n);
        for (int k = k0 + 1; k <= k0 + n; k++) begin
            step();
            chk(tag, pin, (k / half_of(r)) % 2);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset byte", ctrl_byte, 8'h03);
        chk("R1 reset pin", pin, 0);

        // R2: full byte readback, including reserved bits.
        wr(8'h6C);
        chk("R2 readback 6C", ctrl_byte, 8'h6C);
        wr(8'h93);
        chk("R2 readback 93", ctrl_byte, 8'h93);

        // R3: static level under every rate, edges ignored.
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 2; l++) begin
                wr(8'((l << 7) | r));
                for (int e = 0; e < 6; e++) begin
                    step();
                    chk("R3 static level", pin, l);
                end
            end
        end

        // R4, R8, R9: sweep rate x level x reserved with enable set.
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 2; l++) begin
                for (int v = 0; v < 2; v++) begin
                    wr(8'h00);  // disable so the next write restarts
                    wr(8'((l << 7) | (v ? 8'h6C : 8'h00) | 8'h10 | r));
                    chk("R6 starts low", pin, 0);
                    run_wave(l ? "R9 level ignored" : (v ? "R8 reserved ignored" : "R4 rate wave"),
                             2'(r), 0, 2 * half_of(2'(r)) * 2 + 3);
                end
            end
        end

        // R7: write touching only reserved bits keeps the running phase.
        wr(8'h11);
        run_wave("R7 before", 2'b01, 0, 10);
        wr(8'h5D);
        chk("R7 no restart pin", pin, 1);
        run_wave("R7 continues", 2'b01, 10, 20);

        // R6: mid-waveform rate change restarts cleanly.
        wr(8'h12);
        chk("R6 restart low", pin, 0);
        run_wave("R6 full first half", 2'b10, 0, 12);
        // R6: enable change also restarts, then disable drops to level.
        wr(8'h82);
        chk("R6 disable to level", pin, 1);

        // R5: both edges counted; no change without an edge.
        wr(8'h13);
        repeat (4) @(negedge clk);
        chk("R5 no edge no change", pin, 0);
        step();
        chk("R5 rising edge counted", pin, 1);
        step();
        chk("R5 falling edge counted", pin, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule